// File: doc/BRIEF.md
# Critical-word-first line fill

This block handles the refill of one cache line after a miss. The line holds `WORDS` words, and memory returns one word per response. A miss request brings in a word address and an ordering mode. The block issues one memory request per word of the line. Each returned word is written into the cache data array. The word that missed is also handed straight to the processor in the cycle it arrives, so the processor resumes before the rest of the line has landed.

Two fetch orders are available. In wrap order the missed word is requested first and the sequence wraps around the line. In linear order the words are requested from offset zero upward, and the processor is released when the missed word turns up in that sequence.

While a fill is running, the block keeps a per-word presence mask. It uses the mask to hold back any further access to the filling line whose word has not yet been written. It accepts no new miss until the fill has completed. Tag lookup and victim choice belong to the surrounding cache.

Top module: `lf_fill`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, busy, mem_req_valid, cpu_valid, arr_we, line_done and acc_stall are all 0.
- R2: A miss_valid seen while busy is 0 starts a fill: busy is 1 from the next cycle. A miss_valid seen while busy is 1 is ignored: no extra request is issued, and the fill in progress keeps its line and its word order.
- R3: With miss_wrap = 1, the WORDS requests of a fill carry the word addresses {line, (w+k) mod WORDS} for k = 0,1,2,... in that order. Here line is miss_addr without its low log2(WORDS) bits, and w is those low bits, the word offset.
- R4: With miss_wrap = 0, the requests carry {line, k} for k = 0,1,2,... in ascending order, whatever w is.
- R5: cpu_valid is 1 in exactly the cycle in which the response for the missed word is presented, with cpu_data equal to mem_rsp_data. It is 1 once per fill and at no other time.
- R6: Every response taken during a fill drives arr_we = 1 in the same cycle. arr_addr is then the address of the request the response answers (responses return in request order), and arr_data is mem_rsp_data.
- R7: mem_req_valid falls once WORDS requests have been accepted. While mem_req_valid is 1 and mem_req_ready is 0, the request and its address hold steady.
- R8: line_done is a one-cycle pulse in the cycle after the last response of a fill. busy is 0 in that same cycle.
- R9: acc_stall is 1 exactly when acc_valid is 1, a fill is running, acc_addr lies in the filling line, and its word has not been written in an earlier cycle of this fill. Accesses to words already written, to other lines, or with no fill running are not stalled.
- R10: A memory response presented while no fill is running produces no array write and no cpu_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request strobe |
| miss_addr | input | ADDR_W | Word address of the missed access |
| miss_wrap | input | 1 | 1 = wrap order from the missed word, 0 = ascending order |
| busy | output | 1 | A fill is in progress; new misses are not accepted |
| mem_req_valid | output | 1 | Word request to memory is valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | ADDR_W | Word address requested |
| mem_rsp_valid | input | 1 | Memory returns a word this cycle (in request order) |
| mem_rsp_data | input | DATA_W | Returned word |
| cpu_valid | output | 1 | The missed word is on cpu_data |
| cpu_data | output | DATA_W | Word forwarded to the processor |
| arr_we | output | 1 | Data array write enable |
| arr_addr | output | ADDR_W | Data array word address |
| arr_data | output | DATA_W | Data array write data |
| line_done | output | 1 | One-cycle pulse: line complete |
| acc_valid | input | 1 | Another access is probing the array |
| acc_addr | input | ADDR_W | Word address of that access |
| acc_stall | output | 1 | That access must wait |

## Verification
Fills are started at several word offsets in both orders. A wrap fill from a non-zero offset tells rotation apart from plain ascending order, and a fill from offset zero shows the two orders agree there. Memory is run with always-ready, alternating and every-third-cycle acceptance and with response latencies of one to three cycles. This shows whether the request sequence holds under back-pressure and whether forwarding follows the arrival of the missed word rather than a fixed slot. Probes cycling over every word of the filling line, plus a foreign line, separate written from unwritten words and same-line from other-line accesses. A miss raised mid-fill, a stray response while idle and probes while idle check that these stimuli change nothing.

// File: rtl/lf_pkg.sv
package lf_pkg;

    // Order in which the words of a line are requested from memory
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_WRAP   = 1'b1
    } fill_order_e;

endpackage

// File: rtl/lf_order.sv
// Maps a request/response slot number to a word offset inside the line.
module lf_order #(
    parameter int OFF_W = 2
) (
    input  logic [OFF_W-1:0]   crit,
    input  logic [OFF_W-1:0]   slot,
    input  lf_pkg::fill_order_e order,
    output logic [OFF_W-1:0]   word
);

    always_comb begin
        unique case (order)
            lf_pkg::ORD_WRAP: word = crit + slot;  // wraps modulo the line size
            default:          word = slot;
        endcase
    end

endmodule

// File: rtl/lf_mask.sv
// Per-word presence mask of the line being filled.
module lf_mask #(
    parameter int WORDS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      set_en,
    input  logic [$clog2(WORDS)-1:0]  set_idx,
    output logic [WORDS-1:0]          mask,
    output logic                      full
);

    localparam int IDX_W = $clog2(WORDS);

    logic [WORDS-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (clear) begin
            mask_d = '0;
        end else if (set_en) begin
            for (int i = 0; i < WORDS; i++) begin
                if (set_idx == IDX_W'(i)) begin
                    mask_d[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    assign mask = mask_q;
    assign full = &mask_q;

    // R6: between clears a written word never loses its present bit
    mask_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((mask_q & $past(mask_q)) == $past(mask_q)));

    // R6: one write adds at most one present bit
    mask_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ($countones(mask_q) <= $countones($past(mask_q)) + 1));

endmodule

// File: rtl/lf_probe.sv
// Decides whether a concurrent access must wait for the fill.
module lf_probe #(
    parameter int ADDR_W = 16,
    parameter int WORDS  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              acc_valid,
    input  logic [ADDR_W-1:0]                 acc_addr,
    input  logic                              active,
    input  logic [ADDR_W-$clog2(WORDS)-1:0]   line,
    input  logic [WORDS-1:0]                  mask,
    output logic                              stall
);

    localparam int OFF_W  = $clog2(WORDS);
    localparam int LINE_W = ADDR_W - OFF_W;

    logic [LINE_W-1:0] acc_line;
    logic [OFF_W-1:0]  acc_word;
    logic [WORDS-1:0]  word_hit;
    logic              same_line;
    logic              present;

    assign acc_line  = acc_addr[ADDR_W-1:OFF_W];
    assign acc_word  = acc_addr[OFF_W-1:0];
    assign same_line = (acc_line == line);

    genvar g;
    generate
        for (g = 0; g < WORDS; g++) begin : g_word
            assign word_hit[g] = (acc_word == OFF_W'(g)) && mask[g];
        end
    endgenerate

    assign present = |word_hit;
    assign stall   = acc_valid && active && same_line && !present;

    // R9: a probe of a word the mask already holds never waits
    probe_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        present |-> !stall);

endmodule

// File: rtl/lf_fill.sv
// Line-fill engine: wrap or ascending word order, early forward of the missed word.
module lf_fill #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              miss_wrap,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              cpu_valid,
    output logic [DATA_W-1:0] cpu_data,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data,
    output logic              line_done,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              acc_stall
);

    localparam int OFF_W  = $clog2(WORDS);
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int CNT_W  = OFF_W + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORDS);

    typedef struct packed {
        logic                busy;
        lf_pkg::fill_order_e order;
        logic [LINE_W-1:0]   line;
        logic [OFF_W-1:0]    crit;
        logic [CNT_W-1:0]    req_cnt;
        logic [CNT_W-1:0]    rsp_cnt;
        logic                done;
    } fill_st_t;

    fill_st_t st_d, st_q;

    logic             accept;
    logic             req_fire;
    logic             rsp_take;
    logic             last_rsp;
    logic [OFF_W-1:0] req_word;
    logic [OFF_W-1:0] rsp_word;
    logic [WORDS-1:0] mask;
    logic             mask_full;

    // Word offsets for the next request and for the response being taken
    lf_order #(.OFF_W(OFF_W)) u_req_order (
        .crit  (st_q.crit),
        .slot  (st_q.req_cnt[OFF_W-1:0]),
        .order (st_q.order),
        .word  (req_word)
    );

    lf_order #(.OFF_W(OFF_W)) u_rsp_order (
        .crit  (st_q.crit),
        .slot  (st_q.rsp_cnt[OFF_W-1:0]),
        .order (st_q.order),
        .word  (rsp_word)
    );

    assign accept   = miss_valid && !st_q.busy;
    assign req_fire = mem_req_valid && mem_req_ready;
    assign rsp_take = mem_rsp_valid && st_q.busy && (st_q.rsp_cnt < FULL);
    assign last_rsp = rsp_take && (st_q.rsp_cnt == LAST);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.busy    = 1'b1;
            st_d.order   = lf_pkg::fill_order_e'(miss_wrap);
            st_d.line    = miss_addr[ADDR_W-1:OFF_W];
            st_d.crit    = miss_addr[OFF_W-1:0];
            st_d.req_cnt = '0;
            st_d.rsp_cnt = '0;
        end else if (st_q.busy) begin
            if (req_fire) begin
                st_d.req_cnt = st_q.req_cnt + 1'b1;
            end
            if (rsp_take) begin
                st_d.rsp_cnt = st_q.rsp_cnt + 1'b1;
            end
            if (last_rsp) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    lf_mask #(.WORDS(WORDS)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .set_en  (rsp_take),
        .set_idx (rsp_word),
        .mask    (mask),
        .full    (mask_full)
    );

    lf_probe #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_probe (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .active    (st_q.busy),
        .line      (st_q.line),
        .mask      (mask),
        .stall     (acc_stall)
    );

    assign busy          = st_q.busy;
    assign mem_req_valid = st_q.busy && (st_q.req_cnt < FULL);
    assign mem_req_addr  = {st_q.line, req_word};
    assign arr_we        = rsp_take;
    assign arr_addr      = {st_q.line, rsp_word};
    assign arr_data      = mem_rsp_data;
    assign cpu_valid     = rsp_take && (rsp_word == st_q.crit);
    assign cpu_data      = mem_rsp_data;
    assign line_done     = st_q.done;

    // R2
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && miss_valid && !last_rsp) |=> ($stable(st_q.line) && $stable(st_q.crit)));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> (!busy && mask_full));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done);

    // R10
    write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we || cpu_valid) |-> busy);

    // R9
    done_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> !acc_stall);

endmodule

// File: tb/lf_fill_test.sv
module lf_fill_test;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int WORDS  = 4;
    localparam int OFF_W  = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              miss_valid = 1'b0;
    logic [ADDR_W-1:0] miss_addr = '0;
    logic              miss_wrap = 1'b0;
    logic              busy;
    logic              mem_req_valid;
    logic              mem_req_ready;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid;
    logic [DATA_W-1:0] mem_rsp_data;
    logic              cpu_valid;
    logic [DATA_W-1:0] cpu_data;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic [DATA_W-1:0] arr_data;
    logic              line_done;
    logic              acc_valid;
    logic [ADDR_W-1:0] acc_addr;
    logic              acc_stall;

    lf_fill #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) uut (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .miss_wrap(miss_wrap), .busy(busy), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .cpu_valid(cpu_valid), .cpu_data(cpu_data), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_data(arr_data), .line_done(line_done),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_stall(acc_stall)
    );

    typedef struct {
        logic [ADDR_W-1:0] a;
        int                due;
    } pend_t;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [ADDR_W-1:0] exp_req[$];   // scoreboard: expected request addresses
    pend_t             pend[$];      // accepted requests awaiting response

    int                cyc = 0;
    bit                run = 1'b0;
    bit                tb_busy = 1'b0;
    bit                cur_wrap = 1'b0;
    logic [ADDR_W-1:0] crit_addr = '0;
    logic [WORDS-1:0]  tb_mask = '0;
    int                rsp_seen = 0;
    bit                done_pending = 1'b0;
    int                lat = 1;
    int                ready_mode = 0;
    bit                stray_req = 1'b0;
    bit                probe_on = 1'b0;
    int                probe_k = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] data_of(input logic [ADDR_W-1:0] a);
        return {a, ~a} ^ 32'h5A3C_0F96;
    endfunction

    // Memory model and monitor: drives away from the rising edge, samples 1 ns later.
    initial begin
        logic [ADDR_W-1:0] rsp_a;
        logic [ADDR_W-1:0] e;
        bit rsp_on;
        bit stray_on;
        bit exp_cpu;
        bit exp_stall;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        acc_valid     = 1'b0;
        acc_addr      = '0;
        rsp_a         = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (run) begin
                rsp_on   = 1'b0;
                stray_on = 1'b0;
                case (ready_mode)
                    0:       mem_req_ready = 1'b1;
                    1:       mem_req_ready = (cyc % 2 == 0);
                    default: mem_req_ready = (cyc % 3 == 0);
                endcase
                if (pend.size() > 0 && pend[0].due <= cyc) begin
                    rsp_on = 1'b1;
                    rsp_a  = pend[0].a;
                    void'(pend.pop_front());
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = data_of(rsp_a);
                end else if (stray_req && !tb_busy) begin
                    stray_on      = 1'b1;
                    stray_req     = 1'b0;
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = 32'hDEAD_BEEF;
                end else begin
                    mem_rsp_valid = 1'b0;
                end
                if (probe_on) begin
                    acc_valid = 1'b1;
                    if (probe_k % 5 == 4) acc_addr = crit_addr ^ ADDR_W'(1 << OFF_W);
                    else acc_addr = {crit_addr[ADDR_W-1:OFF_W], OFF_W'(probe_k % 4)};
                    probe_k++;
                end else begin
                    acc_valid = 1'b0;
                end
                if (done_pending) tb_busy = 1'b0;
                #1;
                // requests against the scoreboard
                if (mem_req_valid && mem_req_ready) begin
                    if (exp_req.size() == 0) begin
                        chk(1'b0, "R2/R7 unexpected request", 64'(mem_req_addr), 64'(0));
                    end else begin
                        e = exp_req.pop_front();
                        chk(mem_req_addr == e, cur_wrap ? "R3 wrap order" : "R4 linear order",
                            64'(mem_req_addr), 64'(e));
                        pend.push_back('{a: mem_req_addr, due: cyc + lat});
                    end
                end
                // array write and forwarding
                if (rsp_on) begin
                    chk(arr_we == 1'b1, "R6 write enable", 64'(arr_we), 64'(1));
                    chk(arr_addr == rsp_a, "R6 write address", 64'(arr_addr), 64'(rsp_a));
                    chk(arr_data == data_of(rsp_a), "R6 write data", 64'(arr_data), 64'(data_of(rsp_a)));
                    exp_cpu = (rsp_a == crit_addr);
                    chk(cpu_valid == exp_cpu, "R5 forward strobe", 64'(cpu_valid), 64'(exp_cpu));
                    if (exp_cpu)
                        chk(cpu_data == data_of(rsp_a), "R5 forward data", 64'(cpu_data), 64'(data_of(rsp_a)));
                end else begin
                    chk(arr_we == 1'b0, stray_on ? "R10 stray write" : "R6 idle write", 64'(arr_we), 64'(0));
                    chk(cpu_valid == 1'b0, stray_on ? "R10 stray forward" : "R5 idle forward", 64'(cpu_valid), 64'(0));
                end
                chk(line_done == done_pending, "R8 done pulse", 64'(line_done), 64'(done_pending));
                chk(busy == tb_busy, "R2 busy", 64'(busy), 64'(tb_busy));
                done_pending = 1'b0;
                if (probe_on) begin
                    exp_stall = tb_busy && (acc_addr[ADDR_W-1:OFF_W] == crit_addr[ADDR_W-1:OFF_W])
                                && !tb_mask[acc_addr[OFF_W-1:0]];
                    chk(acc_stall == exp_stall, "R9 stall", 64'(acc_stall), 64'(exp_stall));
                end
                if (rsp_on) begin
                    tb_mask[rsp_a[OFF_W-1:0]] = 1'b1;
                    rsp_seen++;
                    if (rsp_seen == WORDS) begin
                        done_pending = 1'b1;
                        rsp_seen = 0;
                    end
                end
            end
        end
    end

    // Driver: starts a fill and pushes its expected request order.
    task automatic start_miss(input logic [ADDR_W-1:0] a, input bit wrap);
        @(negedge clk);
        miss_valid = 1'b1;
        miss_addr  = a;
        miss_wrap  = wrap;
        cur_wrap   = wrap;
        crit_addr  = a;
        tb_mask    = '0;
        for (int k = 0; k < WORDS; k++) begin
            logic [OFF_W-1:0] w;
            w = wrap ? OFF_W'(a[OFF_W-1:0] + OFF_W'(k)) : OFF_W'(k);
            exp_req.push_back({a[ADDR_W-1:OFF_W], w});
        end
        @(negedge clk);
        miss_valid = 1'b0;
        tb_busy    = 1'b1;
    endtask

    task automatic wait_idle();
        forever begin
            @(negedge clk);
            #2;
            if (!tb_busy) break;
        end
    endtask

    task automatic poke_miss(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        #2;
        miss_valid = 1'b1;
        miss_addr  = a;
        miss_wrap  = 1'b0;
        @(negedge clk);
        #2;
        miss_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(busy == 1'b0, "R1 busy", 64'(busy), 64'(0));
        chk(mem_req_valid == 1'b0, "R1 req", 64'(mem_req_valid), 64'(0));
        chk(cpu_valid == 1'b0, "R1 cpu", 64'(cpu_valid), 64'(0));
        chk(arr_we == 1'b0, "R1 write", 64'(arr_we), 64'(0));
        chk(line_done == 1'b0, "R1 done", 64'(line_done), 64'(0));
        chk(acc_stall == 1'b0, "R1 stall", 64'(acc_stall), 64'(0));
        @(negedge clk);
        rst_n = 1'b1;
        run   = 1'b1;

        // R3: wrap from offset 2, fast memory
        ready_mode = 0; lat = 1;
        start_miss(16'h0122, 1'b1);
        wait_idle();

        // R3 R7 R9 R2: wrap from offset 3, back-pressure, probes, miss while busy
        ready_mode = 1; lat = 3; probe_on = 1'b1;
        start_miss(16'h0A57, 1'b1);
        poke_miss(16'h0300);
        wait_idle();
        probe_on = 1'b0;

        // R4 R5: linear order, miss at offset 2 forwarded on third arrival
        ready_mode = 2; lat = 2; probe_on = 1'b1;
        start_miss(16'h0C36, 1'b0);
        wait_idle();
        probe_on = 1'b0;

        // R4/R3 at offset 0: both orders coincide
        ready_mode = 0; lat = 2;
        start_miss(16'h4440, 1'b0);
        wait_idle();
        start_miss(16'h7778, 1'b1);
        poke_miss(16'h7779);
        wait_idle();

        // R10: stray response while idle
        stray_req = 1'b1;
        repeat (3) @(negedge clk);

        // R9: probes with no fill running
        probe_on = 1'b1;
        repeat (6) @(negedge clk);
        probe_on = 1'b0;

        // R5: linear order, miss at last offset
        ready_mode = 1; lat = 1;
        start_miss(16'h2003, 1'b0);
        wait_idle();
        repeat (3) @(negedge clk);

        chk(exp_req.size() == 0, "R7 requests outstanding", 64'(exp_req.size()), 64'(0));
        chk(pend.size() == 0, "R6 responses outstanding", 64'(pend.size()), 64'(0));
        finish_run();
    end

endmodule